// File: doc/BRIEF.md
# Sample-Aligned FIFO Readout Channel

This block is the read side of a sensor data queue. A sensor-side producer pushes 32-bit words into a 64-entry store. A bus-side consumer pulls the words out one at a time. A request line tells a DMA engine when at least one complete sample is ready. A sample is a fixed group of `SAMPLE_LEN` consecutive words.

One 32-bit control word holds two persistent gates and three self-clearing commands. The DMA gate masks the request line. The readout gate makes the reader see an empty queue while the producer keeps writing.

The commands act on the read side only:
- Discard all unread data.
- Skip the rest of a partially read sample, so the reader lands on the first word of the next sample.
- Clear a sticky error flag. The flag records any pull made while nothing was visible.

A status word reports that flag and the visible word count.

Top module: `sensor_fifo_rdch`

## Requirements
- R1: After reset the control readback is 0x00000000, the status word is 0 and `dma_req` is 0. Only control bits 25 and 24 can read back as 1.
- R2: While control bit 25 (DMA gate) is 0, `dma_req` is 0 at every fill level.
- R3: While control bit 24 (readout gate) is 0, the visible count in status bits [6:0] is 0 and pulls behave as on an empty queue. Words pushed during that time are still stored and become visible once the bit is set again.
- R4: A pull (`rd_req`) with a nonzero visible count presents the oldest unread word on `rd_data` in the cycle after the request, and lowers the count by one.
- R5: Writing control bit 16 as 1 discards all unread words, so the count becomes 0. The bit reads back 0.
- R6: Writing control bit 8 as 1 while the last pull ended partway through a sample skips the remaining words of that sample. Written at a sample boundary, it changes nothing.
- R7: A skip (bit 8) that would pass the newest written word stops there. The count becomes 0, and the next word pushed is the next word pulled.
- R8: A pull with a visible count of 0 sets status bit 31. The flag stays set, `rd_data` becomes 0, and the read position does not move.
- R9: Writing control bit 1 as 1 clears status bit 31. If an empty pull happens in the same cycle, the flag stays set.
- R10: `dma_req` is 1 exactly when bits 25 and 24 are both 1 and the visible count is at least `SAMPLE_LEN`.
- R11: At 64 stored words, `wr_full` is 1 and further pushes are dropped without disturbing stored words.
- R12: A pull in the same cycle as a discard (bit 16) or skip (bit 8) command is ignored. `rd_data` holds its value and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Producer push strobe |
| wr_data | input | 32 | Producer word |
| wr_full | output | 1 | Store holds 64 words |
| rd_req | input | 1 | Consumer pull strobe |
| rd_data | output | 32 | Pulled word, valid the cycle after a pull |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Control word readback |
| stat_rdata | output | 32 | Bit 31 error flag, bits [6:0] visible count |
| dma_req | output | 1 | Sample-ready request to the DMA engine |

## Verification
The hardest case to reach is a skip command that would run past the newest written word. This needs a read position that is mid-sample while fewer words remain than the rest of that sample.

The bench builds the case in steps:
1. Discard all unread data, which also resets the in-sample position.
2. Push two words.
3. Pull one word, leaving the read position mid-sample with one word left.
4. Issue the skip.
5. Push one more word and pull it, to prove the read position sits exactly at the newest written word.

A second hard case is an empty pull in the same cycle as the flag clear. The bench reaches it by draining the queue first.

// File: rtl/srfifo_pkg.sv
// Package srfifo_pkg
// Bit positions of the control word. Software decodes these, so they are fixed.
package srfifo_pkg;
    localparam int CB_DMA_EN   = 25;
    localparam int CB_RD_EN    = 24;
    localparam int CB_FLUSH    = 16;
    localparam int CB_REALIGN  = 8;
    localparam int CB_UCLR     = 1;
    localparam int SB_UNDERRUN = 31;
endpackage

// File: rtl/srfifo_ctrl_reg.sv
// Module srfifo_ctrl_reg
// Holds the two persistent gates and decodes the three self-clearing commands.
// Assumes a single-cycle write strobe. The command outputs are combinational
// from the strobe, so they act at the same edge that captures the gates.
module srfifo_ctrl_reg
    import srfifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic        dma_en,
    output logic        rd_en,
    output logic        cmd_flush,
    output logic        cmd_realign,
    output logic        cmd_uclr,
    output logic [31:0] rdata
);
    // Capture the persistent gate bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en <= 1'b0;
            rd_en  <= 1'b0;
        end else if (we) begin
            dma_en <= wdata[CB_DMA_EN];
            rd_en  <= wdata[CB_RD_EN];
        end
    end

    // Decode command pulses and build the readback; command bits read as zero.
    always_comb begin
        cmd_flush   = we & wdata[CB_FLUSH];
        cmd_realign = we & wdata[CB_REALIGN];
        cmd_uclr    = we & wdata[CB_UCLR];
        rdata              = '0;
        rdata[CB_DMA_EN]   = dma_en;
        rdata[CB_RD_EN]    = rd_en;
    end
endmodule

// File: rtl/srfifo_store.sv
// Module srfifo_store
// Word storage and write pointer. The pointer carries one extra wrap bit.
// A push is accepted when the raw fill is below DEPTH. Reads are registered;
// an empty pull loads zero. Assumes DEPTH is a power of two.
module srfifo_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rptr,
    input  logic          rd_fire,
    input  logic          rd_zero,
    output logic [PW-1:0] wptr,
    output logic          full,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] fill;

    // Raw occupancy and full flag.
    always_comb begin
        fill = wptr - rptr;
        full = (fill == PW'(DEPTH));
    end

    // Accept producer words while space remains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (wr_valid && !full) begin
            wptr <= wptr + 1'b1;
        end
    end

    // Storage array, written without reset.
    always_ff @(posedge clk) begin
        if (wr_valid && !full) begin
            mem[wptr[AW-1:0]] <= wr_data;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (rd_fire) begin
            q <= mem[rptr[AW-1:0]];
        end else if (rd_zero) begin
            q <= '0;
        end
    end
endmodule

// File: rtl/srfifo_rd_ctrl.sv
// Module srfifo_rd_ctrl
// Read pointer, word-within-sample counter, visible count and sticky
// underrun flag. Command priority: discard, then skip, then pull. A pull
// in a command cycle is ignored. Assumes 1 <= SAMPLE_LEN <= 8.
module srfifo_rd_ctrl #(
    parameter int DEPTH      = 64,
    parameter int SAMPLE_LEN = 4,
    localparam int AW        = $clog2(DEPTH),
    localparam int PW        = AW + 1,
    localparam int SCW       = (SAMPLE_LEN > 1) ? $clog2(SAMPLE_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wptr,
    input  logic          rd_en,
    input  logic          rd_req,
    input  logic          cmd_flush,
    input  logic          cmd_realign,
    input  logic          cmd_uclr,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] vis_cnt,
    output logic          rd_fire,
    output logic          rd_zero,
    output logic          underrun
);
    logic [SCW-1:0] wsc;
    logic [PW-1:0]  fill;
    logic [PW-1:0]  skip;
    logic           pull_ok;

    // Fill, visible count, skip distance and pull qualification.
    always_comb begin
        fill    = wptr - rptr;
        vis_cnt = rd_en ? fill : '0;
        skip    = PW'(SAMPLE_LEN) - PW'(wsc);
        pull_ok = rd_req && !cmd_flush && !cmd_realign;
        rd_fire = pull_ok && (vis_cnt != '0);
        rd_zero = pull_ok && (vis_cnt == '0);
    end

    // Move the read pointer and the in-sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            wsc  <= '0;
        end else if (cmd_flush) begin
            rptr <= wptr;
            wsc  <= '0;
        end else if (cmd_realign) begin
            if (wsc != '0) begin
                rptr <= (skip >= fill) ? wptr : rptr + skip;
            end
            wsc <= '0;
        end else if (rd_fire) begin
            rptr <= rptr + 1'b1;
            wsc  <= (wsc == SCW'(SAMPLE_LEN - 1)) ? '0 : wsc + 1'b1;
        end
    end

    // Sticky underrun flag; a new empty pull wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (rd_zero) begin
            underrun <= 1'b1;
        end else if (cmd_uclr) begin
            underrun <= 1'b0;
        end
    end
endmodule

// File: rtl/sensor_fifo_rdch.sv
// Module sensor_fifo_rdch
// Sample-aligned readout channel. It joins the control word, the storage and
// the read controller, and forms the DMA request and the status word.
// Assumes a single clock domain for producer, consumer and control.
module sensor_fifo_rdch #(
    parameter int DEPTH      = 64,
    parameter int SAMPLE_LEN = 4,
    localparam int DW        = 32,
    localparam int PW        = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_full,
    input  logic        rd_req,
    output logic [31:0] rd_data,
    input  logic        ctrl_we,
    input  logic [31:0] ctrl_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] stat_rdata,
    output logic        dma_req
);
    import srfifo_pkg::*;

    logic          dma_en, rd_en, cmd_flush, cmd_realign, cmd_uclr;
    logic [PW-1:0] wptr, rptr, vis_cnt;
    logic          rd_fire, rd_zero, underrun;

    srfifo_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
        .dma_en(dma_en), .rd_en(rd_en), .cmd_flush(cmd_flush),
        .cmd_realign(cmd_realign), .cmd_uclr(cmd_uclr), .rdata(ctrl_rdata)
    );

    srfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rptr(rptr), .rd_fire(rd_fire), .rd_zero(rd_zero),
        .wptr(wptr), .full(wr_full), .q(rd_data)
    );

    srfifo_rd_ctrl #(.DEPTH(DEPTH), .SAMPLE_LEN(SAMPLE_LEN)) u_rd (
        .clk(clk), .rst_n(rst_n), .wptr(wptr), .rd_en(rd_en), .rd_req(rd_req),
        .cmd_flush(cmd_flush), .cmd_realign(cmd_realign), .cmd_uclr(cmd_uclr),
        .rptr(rptr), .vis_cnt(vis_cnt), .rd_fire(rd_fire), .rd_zero(rd_zero),
        .underrun(underrun)
    );

    // DMA request and status word.
    always_comb begin
        dma_req                 = dma_en && rd_en && (vis_cnt >= PW'(SAMPLE_LEN));
        stat_rdata              = '0;
        stat_rdata[PW-1:0]      = vis_cnt;
        stat_rdata[SB_UNDERRUN] = underrun;
    end
endmodule

// File: rtl/srfifo_chk.sv
// Module srfifo_chk
// Port-level properties of the readout channel, attached by bind.
module srfifo_chk #(
    parameter int DEPTH      = 64,
    parameter int SAMPLE_LEN = 4,
    localparam int PW        = $clog2(DEPTH) + 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic [31:0] wr_data,
    input logic        wr_full,
    input logic        rd_req,
    input logic [31:0] rd_data,
    input logic        ctrl_we,
    input logic [31:0] ctrl_wdata,
    input logic [31:0] ctrl_rdata,
    input logic [31:0] stat_rdata,
    input logic        dma_req
);
    logic [PW-1:0] cnt;
    logic          uflag, cmd_any;
    assign cnt     = stat_rdata[PW-1:0];
    assign uflag   = stat_rdata[31];
    assign cmd_any = ctrl_we && (ctrl_wdata[16] || ctrl_wdata[8]);

    // R1: only the two gate bits can read back as one
    always_comb begin
        if (rst_n) a_r1_ctrl_reserved: assert ((ctrl_rdata & 32'hFCFF_FFFF) == 32'h0);
    end

    a_r2_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[25] |-> !dma_req);

    a_r3_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[24] |-> cnt == '0);

    a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[16] && !wr_valid) |=> cnt == '0);

    a_r8_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cnt == '0 && !cmd_any) |=> (uflag && rd_data == 32'h0));

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uflag && !(ctrl_we && ctrl_wdata[1])) |=> uflag);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[1] && !rd_req) |=> !uflag);

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= PW'(DEPTH));

    a_r12_cmd_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_any && rd_req) |=> $stable(rd_data));
endmodule

bind sensor_fifo_rdch srfifo_chk #(.DEPTH(DEPTH), .SAMPLE_LEN(SAMPLE_LEN)) u_chk (.*);

// File: tb/sensor_fifo_rdch_test.sv
module sensor_fifo_rdch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_full;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [31:0] stat_rdata;
    logic        dma_req;
    int total = 0;
    int bad = 0;

    localparam logic [31:0] RDON = 32'h0100_0000;
    localparam logic [31:0] BOTH = 32'h0300_0000;

    always #2 clk = ~clk;

    sensor_fifo_rdch #(.DEPTH(64), .SAMPLE_LEN(4)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic ctrl(input logic [31:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic push(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1; wr_data = base + 32'(i);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic pop(input string req, input logic [31:0] exp);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(req, rd_data, exp);
    endtask

    function automatic logic [31:0] cnt();
        return stat_rdata & 32'h7F;
    endfunction

    task automatic t_reset;
        chk("R1 ctrl", ctrl_rdata, 32'h0);
        chk("R1 stat", stat_rdata, 32'h0);
        chk("R1 dma", 32'(dma_req), 32'h0);
        ctrl(32'hFFFF_FFFF);
        chk("R1 readback only gates", ctrl_rdata, BOTH);
        ctrl(32'h0001_0000);
        chk("R5 flush bit reads 0", ctrl_rdata, 32'h0);
    endtask

    task automatic t_dma_and_read;
        ctrl(RDON);
        push(8, 32'h100);
        chk("R3 count", cnt(), 32'd8);
        chk("R2 gate off", 32'(dma_req), 32'h0);
        ctrl(BOTH);
        chk("R10 dma on", 32'(dma_req), 32'h1);
        pop("R4 first word", 32'h100);
        chk("R4 count dec", cnt(), 32'd7);
    endtask

    task automatic t_realign;
        ctrl(BOTH | 32'h100);
        chk("R6 skip count", cnt(), 32'd4);
        pop("R6 next sample", 32'h104);
        pop("R4 order", 32'h105);
        pop("R4 order", 32'h106);
        pop("R4 order", 32'h107);
        push(8, 32'h200);
        ctrl(BOTH | 32'h100);
        chk("R6 boundary no move", cnt(), 32'd8);
        pop("R6 boundary data", 32'h200);
    endtask

    task automatic t_clamp;
        ctrl(BOTH | 32'h1_0000);
        chk("R5 flush count", cnt(), 32'd0);
        push(2, 32'h300);
        pop("R7 setup", 32'h300);
        chk("R10 below sample", 32'(dma_req), 32'h0);
        ctrl(BOTH | 32'h100);
        chk("R7 clamp count", cnt(), 32'd0);
        push(1, 32'h302);
        pop("R7 next word", 32'h302);
    endtask

    task automatic t_underrun;
        pop("R8 empty data", 32'h0);
        chk("R8 flag", stat_rdata[31], 1'b1);
        push(1, 32'h400);
        pop("R8 pointer held", 32'h400);
        chk("R8 sticky", stat_rdata[31], 1'b1);
        ctrl(BOTH | 32'h2);
        chk("R9 cleared", stat_rdata[31], 1'b0);
        rd_req = 1'b1; ctrl_we = 1'b1; ctrl_wdata = BOTH | 32'h2;
        @(negedge clk);
        rd_req = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0;
        chk("R9 set wins", stat_rdata[31], 1'b1);
        ctrl(BOTH | 32'h2);
    endtask

    task automatic t_hidden;
        ctrl(32'h0200_0000);
        push(5, 32'h500);
        chk("R3 hidden count", cnt(), 32'd0);
        chk("R2 dma hidden", 32'(dma_req), 32'h0);
        pop("R3 empty pull", 32'h0);
        chk("R3 flag", stat_rdata[31], 1'b1);
        ctrl(BOTH | 32'h2);
        chk("R3 visible again", cnt(), 32'd5);
        pop("R3 stored data", 32'h500);
    endtask

    task automatic t_full;
        ctrl(BOTH | 32'h1_0000);
        push(70, 32'h600);
        chk("R11 count", cnt(), 32'd64);
        chk("R11 full", 32'(wr_full), 32'h1);
        pop("R11 oldest kept", 32'h600);
        pop("R11 order", 32'h601);
    endtask

    task automatic t_cmd_pull;
        rd_req = 1'b1; ctrl_we = 1'b1; ctrl_wdata = BOTH | 32'h1_0000;
        @(negedge clk);
        rd_req = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0;
        chk("R12 data held", rd_data, 32'h601);
        chk("R12 no flag", stat_rdata[31], 1'b0);
        chk("R12 flushed", cnt(), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dma_and_read();
        t_realign();
        t_clamp();
        t_underrun();
        t_hidden();
        t_full();
        t_cmd_pull();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule